// File: doc/BRIEF.md
# Serializing Issue Gate

This block decides, every cycle, whether the instruction now leaving decode in a simple in-order pipeline may go on to the execution units. It keeps a count of instructions that have been sent out but not yet reported finished. It also keeps a small ordered record of what each of those instructions will write, so that a reader of a pending result is held back. Some instructions must have the whole back end to themselves. For these the block first lets older work drain, then sends the instruction, then holds everything behind it until the instruction finishes.

Decode presents its instruction together with the register indices the instruction reads and writes. It keeps presenting the same instruction while the stall output is high. The back end returns one completion pulse per finished instruction, in issue order. A flush drops the current instruction without any side effect. A stop marker on an instruction parks the block for good once the pipeline is empty. Only reset leaves that parked state.

Top module: `issue_ctl`

## Requirements
- R1: While reset is high and on the first cycle after it, issue_ok, stall and stopped are 0 and nothing is outstanding. A plain valid instruction then issues at once.
- R2: A valid, unflushed, hazard-free instruction issues in the same cycle (issue_ok=1, stall=0). A valid instruction that is held shows stall=1 and issue_ok=0.
- R3: Each issue adds one to the outstanding count and each done pulse removes one. A done pulse while nothing is outstanding is ignored. With DEPTH instructions outstanding after the current cycle's done, a further instruction stalls.
- R4: A single-pipe instruction (solo=1) that arrives while instructions are still outstanding stalls. It issues in the cycle the count, after that cycle's done, reaches zero.
- R5: After a single-pipe instruction issues, every later instruction stalls until its done pulse arrives. In that cycle the next plain instruction may issue.
- R6: While flush=1, issue_ok and stall are 0. A single-pipe instruction seen under flush starts no wait, so a plain instruction in the next cycle issues even with work outstanding.
- R7: A read port with its enable set whose index equals the write index of a pending writing instruction stalls issue. A disabled read port never causes a stall. An entry whose done pulse arrives in the same cycle is no longer pending.
- R8: cr_rd=1 stalls while any pending instruction has cr_wr=1. The same-cycle done rule of R7 applies.
- R9: A valid, unflushed instruction with stop_req=1 does not issue and stalls. stopped rises on the clock edge where nothing remains outstanding. From then on it stays 1 and nothing issues until reset.
- R10: The outstanding count never exceeds DEPTH and never exceeds one while a single-pipe instruction is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decode presents an instruction |
| flush | input | 1 | Discard the presented instruction |
| done | input | 1 | One instruction finished in the back end |
| solo | input | 1 | Instruction must run alone |
| stop_req | input | 1 | Stop marker on the instruction |
| rd_a_en | input | 1 | First read port used |
| rd_a_idx | input | IDX_W | First read register index |
| rd_b_en | input | 1 | Second read port used |
| rd_b_idx | input | IDX_W | Second read register index |
| rd_c_en | input | 1 | Third read port used |
| rd_c_idx | input | IDX_W | Third read register index |
| wr_en | input | 1 | Instruction writes a register |
| wr_idx | input | IDX_W | Written register index |
| cr_rd | input | 1 | Instruction reads the condition register |
| cr_wr | input | 1 | Instruction writes the condition register |
| issue_ok | output | 1 | Instruction issues this cycle |
| stall | output | 1 | Decode must hold its instruction |
| stopped | output | 1 | Block has parked after a stop marker |

## Verification
The bench builds the block with its defaults: a pipeline depth of 2 and 5-bit register indices. With only two slots, a full pipeline is reached after two issues. A third instruction then exercises the full-stall path, and done pulses in the same cycle as a new request cover both the head-entry release of the hazard record and the drain condition of the single-pipe sequence. Done pulses applied with nothing outstanding show up at the ports, because the later fill pattern stalls one instruction earlier or later than it should if the count has wrapped.

// File: rtl/issue_pkg.sv
`timescale 1ns/1ps
package issue_pkg;
  typedef enum logic [1:0] {
    SQ_FREE  = 2'd0,
    SQ_DRAIN = 2'd1,
    SQ_ALONE = 2'd2
  } seq_t;
endpackage

// File: rtl/issue_count.sv
`timescale 1ns/1ps
module issue_count #(
  parameter int DEPTH = 2,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic             take,
  output logic [CNT_W-1:0] cnt_q,
  output logic             done_ok,
  output logic [CNT_W-1:0] eff,
  output logic             eff_zero,
  output logic             full
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  // a completion with nothing in flight is dropped
  assign done_ok  = done && (cnt_q != '0);
  assign eff      = cnt_q - CNT_W'(done_ok);
  assign eff_zero = (eff == '0);
  assign full     = (eff == CAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= eff + CNT_W'(take);
    end
  end
endmodule

// File: rtl/issue_seq.sv
`timescale 1ns/1ps
module issue_seq
  import issue_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic solo,
  input  logic eff_zero,
  output logic allow,
  output seq_t st_q
);
  seq_t st_d;

  always_comb begin
    allow = 1'b0;
    st_d  = st_q;
    unique case (st_q)
      SQ_FREE: begin
        allow = !(solo && !eff_zero);
        if (req && solo) begin
          st_d = eff_zero ? SQ_ALONE : SQ_DRAIN;
        end
      end
      SQ_DRAIN: begin
        allow = eff_zero;
        if (eff_zero) begin
          st_d = SQ_ALONE;
        end
      end
      SQ_ALONE: begin
        // a new single-pipe request must restart from the free state
        allow = eff_zero && !solo;
        if (eff_zero) begin
          st_d = SQ_FREE;
        end
      end
      default: begin
        allow = 1'b0;
        st_d  = SQ_FREE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SQ_FREE;
    end else begin
      st_q <= st_d;
    end
  end
endmodule

// File: rtl/issue_board.sv
`timescale 1ns/1ps
module issue_board #(
  parameter int DEPTH  = 2,
  parameter int IDX_W  = 5,
  parameter int NUM_RD = 3,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CNT_W-1:0]             cnt_q,
  input  logic                         pop,
  input  logic                         push,
  input  logic [CNT_W-1:0]             slot_in,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic                         cr_wr,
  input  logic [NUM_RD-1:0]            rd_en,
  input  logic [NUM_RD-1:0][IDX_W-1:0] rd_idx,
  input  logic                         cr_rd,
  output logic                         hazard
);
  // slot 0 holds the oldest in-flight instruction
  logic [DEPTH-1:0]            g_v;
  logic [DEPTH-1:0]            c_v;
  logic [DEPTH-1:0][IDX_W-1:0] g_idx;
  logic [DEPTH-1:0]            live;
  logic [DEPTH-1:0]            g_hit;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [NUM_RD-1:0] same;
    logic              nx_g;
    logic              nx_c;
    logic [IDX_W-1:0]  nx_idx;

    assign live[s] = (CNT_W'(s) < cnt_q) && !(pop && (s == 0));

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
      assign same[p] = rd_en[p] && (rd_idx[p] == g_idx[s]);
    end
    assign g_hit[s] = live[s] && g_v[s] && (|same);

    if (s == DEPTH - 1) begin : g_top
      assign nx_g   = pop ? 1'b0 : g_v[s];
      assign nx_c   = pop ? 1'b0 : c_v[s];
      assign nx_idx = pop ? '0 : g_idx[s];
    end else begin : g_mid
      assign nx_g   = pop ? g_v[s+1]   : g_v[s];
      assign nx_c   = pop ? c_v[s+1]   : c_v[s];
      assign nx_idx = pop ? g_idx[s+1] : g_idx[s];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        g_v[s]   <= 1'b0;
        c_v[s]   <= 1'b0;
        g_idx[s] <= '0;
      end else if (push && (slot_in == CNT_W'(s))) begin
        g_v[s]   <= wr_en;
        c_v[s]   <= cr_wr;
        g_idx[s] <= wr_idx;
      end else begin
        g_v[s]   <= nx_g;
        c_v[s]   <= nx_c;
        g_idx[s] <= nx_idx;
      end
    end
  end

  assign hazard = (|g_hit) || (cr_rd && (|(live & c_v)));
endmodule

// File: rtl/issue_ctl.sv
`timescale 1ns/1ps
module issue_ctl
  import issue_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             flush,
  input  logic             done,
  input  logic             solo,
  input  logic             stop_req,
  input  logic             rd_a_en,
  input  logic [IDX_W-1:0] rd_a_idx,
  input  logic             rd_b_en,
  input  logic [IDX_W-1:0] rd_b_idx,
  input  logic             rd_c_en,
  input  logic [IDX_W-1:0] rd_c_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             cr_rd,
  input  logic             cr_wr,
  output logic             issue_ok,
  output logic             stall,
  output logic             stopped
);
  localparam int NUM_RD = 3;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] eff;
  logic             done_ok;
  logic             eff_zero;
  logic             full;
  logic             allow;
  logic             hazard;
  logic             halt_q;
  logic             stopped_q;
  logic             live_in;
  logic             mark;
  logic             req;
  logic             go;
  seq_t             st_q;

  assign live_in = in_valid && !flush && !rst;
  assign mark    = live_in && stop_req;
  assign req     = live_in && !mark && !halt_q && !stopped_q;
  assign go      = req && allow && !hazard && !full;

  issue_count #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .done(done), .take(go),
    .cnt_q(cnt_q), .done_ok(done_ok), .eff(eff),
    .eff_zero(eff_zero), .full(full)
  );

  issue_seq u_seq (
    .clk(clk), .rst(rst), .req(req), .solo(solo),
    .eff_zero(eff_zero), .allow(allow), .st_q(st_q)
  );

  issue_board #(.DEPTH(DEPTH), .IDX_W(IDX_W), .NUM_RD(NUM_RD), .CNT_W(CNT_W)) u_board (
    .clk(clk), .rst(rst), .cnt_q(cnt_q), .pop(done_ok), .push(go),
    .slot_in(eff), .wr_en(wr_en), .wr_idx(wr_idx), .cr_wr(cr_wr),
    .rd_en({rd_c_en, rd_b_en, rd_a_en}),
    .rd_idx({rd_c_idx, rd_b_idx, rd_a_idx}),
    .cr_rd(cr_rd), .hazard(hazard)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q    <= 1'b0;
      stopped_q <= 1'b0;
    end else begin
      if (mark) begin
        halt_q <= 1'b1;
      end
      if ((halt_q || mark) && eff_zero) begin
        stopped_q <= 1'b1;
      end
    end
  end

  assign issue_ok = go;
  assign stall    = live_in && !go;
  assign stopped  = stopped_q;
endmodule

// File: rtl/issue_ctl_chk.sv
`timescale 1ns/1ps
module issue_ctl_chk
  import issue_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             done,
  input logic             issue_ok,
  input logic             stall,
  input logic             stopped,
  input logic             hazard,
  input logic [CNT_W-1:0] cnt,
  input seq_t             st
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt == '0 && st == SQ_FREE && !stopped));

  a_r3_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  a_r3_inc: assert property (@(posedge clk) disable iff (rst)
    (issue_ok && !done) |=> (cnt == $past(cnt) + CNT_W'(1)));

  a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && done && !issue_ok) |=> (cnt == '0));

  a_r5_hold_behind: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_ALONE && cnt != '0 && !done) |-> !issue_ok);

  a_r6_flush_quiet: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!issue_ok && !stall));

  a_r7_hazard_blocks: assert property (@(posedge clk) disable iff (rst)
    hazard |-> !issue_ok);

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    stopped |=> stopped);

  a_r9_no_issue: assert property (@(posedge clk) disable iff (rst)
    stopped |-> !issue_ok);

  a_r10_alone_single: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_ALONE) |-> (cnt <= CNT_W'(1)));
endmodule

bind issue_ctl issue_ctl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .done(done), .issue_ok(issue_ok),
  .stall(stall), .stopped(stopped), .hazard(hazard), .cnt(cnt_q), .st(st_q)
);

// File: tb/test_issue_ctl.sv
`timescale 1ns/1ps
module test_issue_ctl;
  localparam int DEPTH = 2;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid, flush, done, solo, stop_req;
  logic rd_a_en, rd_b_en, rd_c_en, wr_en, cr_rd, cr_wr;
  logic [IDX_W-1:0] rd_a_idx, rd_b_idx, rd_c_idx, wr_idx;
  logic issue_ok, stall, stopped;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  issue_ctl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_issue_ctl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .flush(flush), .done(done),
    .solo(solo), .stop_req(stop_req),
    .rd_a_en(rd_a_en), .rd_a_idx(rd_a_idx),
    .rd_b_en(rd_b_en), .rd_b_idx(rd_b_idx),
    .rd_c_en(rd_c_en), .rd_c_idx(rd_c_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .cr_rd(cr_rd), .cr_wr(cr_wr),
    .issue_ok(issue_ok), .stall(stall), .stopped(stopped)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic clr();
    in_valid = 0; flush = 0; done = 0; solo = 0; stop_req = 0;
    rd_a_en = 0; rd_b_en = 0; rd_c_en = 0; wr_en = 0; cr_rd = 0; cr_wr = 0;
    rd_a_idx = '0; rd_b_idx = '0; rd_c_idx = '0; wr_idx = '0;
  endtask

  // inputs are set at a falling edge; outputs are checked 1 ns later
  task automatic cyc(input string tag, input logic ei, input logic es);
    #1;
    chk({tag, " issue_ok"}, issue_ok, ei);
    chk({tag, " stall"}, stall, es);
    @(negedge clk);
    clr();
  endtask

  task automatic do_reset();
    clr();
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset();
    clr();
    rst = 1;
    @(negedge clk);
    in_valid = 1;
    #1;
    chk("R1 issue in reset", issue_ok, 1'b0);
    chk("R1 stall in reset", stall, 1'b0);
    chk("R1 stopped in reset", stopped, 1'b0);
    @(negedge clk);
    clr();
    rst = 0;
    #1;
    chk("R1 stopped after reset", stopped, 1'b0);
    @(negedge clk);
    in_valid = 1; cyc("R1 first issue", 1, 0);
  endtask

  task automatic t_count();
    do_reset();
    in_valid = 1; cyc("R2 free issue a", 1, 0);
    in_valid = 1; cyc("R2 free issue b", 1, 0);
    in_valid = 1; cyc("R3 full stall", 0, 1);
    in_valid = 1; done = 1; cyc("R3 slot freed same cycle", 1, 0);
    done = 1; cyc("R3 drain 1", 0, 0);
    done = 1; cyc("R3 drain 2", 0, 0);
    done = 1; cyc("R3 done at zero", 0, 0);
    in_valid = 1; cyc("R3 refill a", 1, 0);
    in_valid = 1; cyc("R3 refill b", 1, 0);
    in_valid = 1; cyc("R3 refill full", 0, 1);
  endtask

  task automatic t_solo_wait();
    do_reset();
    in_valid = 1; cyc("R4 older", 1, 0);
    in_valid = 1; solo = 1; cyc("R4 solo waits", 0, 1);
    in_valid = 1; solo = 1; cyc("R4 solo still waits", 0, 1);
    in_valid = 1; solo = 1; done = 1; cyc("R4 solo issues on drain", 1, 0);
    in_valid = 1; cyc("R5 behind solo", 0, 1);
    in_valid = 1; done = 1; cyc("R5 release after solo", 1, 0);
  endtask

  task automatic t_solo_now();
    do_reset();
    in_valid = 1; solo = 1; cyc("R5 solo at once", 1, 0);
    in_valid = 1; cyc("R5 held a", 0, 1);
    in_valid = 1; cyc("R5 held b", 0, 1);
    in_valid = 1; done = 1; cyc("R5 released", 1, 0);
  endtask

  task automatic t_flush();
    do_reset();
    in_valid = 1; cyc("R6 older", 1, 0);
    in_valid = 1; solo = 1; flush = 1; cyc("R6 flushed solo", 0, 0);
    in_valid = 1; cyc("R6 no wait started", 1, 0);
    in_valid = 1; flush = 1; cyc("R6 flushed plain", 0, 0);
  endtask

  task automatic t_raw();
    do_reset();
    in_valid = 1; wr_en = 1; wr_idx = 5'd7; cyc("R7 writer", 1, 0);
    in_valid = 1; rd_b_en = 1; rd_b_idx = 5'd7; cyc("R7 reader stalls", 0, 1);
    in_valid = 1; rd_b_idx = 5'd7; rd_a_en = 1; rd_a_idx = 5'd8;
    cyc("R7 disabled port ignored", 1, 0);
    do_reset();
    in_valid = 1; wr_en = 1; wr_idx = 5'd7; cyc("R7 writer again", 1, 0);
    in_valid = 1; rd_c_en = 1; rd_c_idx = 5'd7; done = 1;
    cyc("R7 same-cycle completion", 1, 0);
  endtask

  task automatic t_cr();
    do_reset();
    in_valid = 1; cr_wr = 1; cyc("R8 cr writer", 1, 0);
    in_valid = 1; cr_rd = 1; cyc("R8 cr reader stalls", 0, 1);
    in_valid = 1; cr_rd = 1; done = 1; cyc("R8 cr released", 1, 0);
  endtask

  task automatic t_stop();
    do_reset();
    in_valid = 1; cyc("R9 older", 1, 0);
    in_valid = 1; stop_req = 1; cyc("R9 marked", 0, 1);
    chk("R9 not yet stopped", stopped, 1'b0);
    in_valid = 1; cyc("R9 waiting", 0, 1);
    in_valid = 1; done = 1; cyc("R9 draining", 0, 1);
    #1; chk("R9 stopped raised", stopped, 1'b1);
    for (int k = 0; k < 3; k++) begin
      in_valid = 1; cyc("R9 parked", 0, 1);
      chk("R9 stays stopped", stopped, 1'b1);
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clr();
    t_reset();
    t_count();
    t_solo_wait();
    t_solo_now();
    t_flush();
    t_raw();
    t_cr();
    t_stop();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule